// File: doc/BRIEF.md
# Shared-Bus Times-Five Sequencer

This block multiplies a stored register value by five using only additions. A small datapath holds three registers: the accumulator, an adder operand, and a running total. It also has one adder and a single shared data bus. A Moore controller steps through a fixed schedule of ten steps. Each step may enable one bus source and one register load. The bus has only two possible sources, the accumulator or the running-total register. Inside the chip the bus is a multiplexer selected by those two enables. When neither enable is set, the bus carries no meaningful value.

A user first writes the starting value through the preload port, then pulses `start`. After ten steps the accumulator holds five times its old value, wrapped to the datapath width. The controller then parks in a terminal step and raises `done`. Another `start` runs the schedule again on the current accumulator, so each extra run multiplies it by five once more.

Top module: `mul5_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other stimulus, `done` is 1 and `acc_out` is 0. The controller is parked in its terminal step, numbered 10.
- R2: While parked, a cycle with `preload` high writes `preload_data` into the accumulator. The new value appears on `acc_out` after that clock edge.
- R3: A clock edge that samples `start` high puts the controller in step 0. From that edge, `done` is 0.
- R4: With `start` low, the controller advances exactly one step per clock from step 0 through step 9, then reaches step 10. `done` therefore rises on the tenth clock edge after the edge that captured `start`, and it is high only in step 10.
- R5: When `done` rises, `acc_out` equals five times the accumulator value at the start of the run, modulo 2^WIDTH.
- R6: In each step at most one bus source is enabled. A register never loads in a step where the bus is idle; steps 2, 6 and 8 are idle.
- R7: While parked with `start` and `preload` low, `done` stays 1 and `acc_out` does not change.
- R8: A `start` sampled in any step, including in the middle of a run, restarts the schedule from step 0. The restarted run still produces five times the value the accumulator had before the run.
- R9: A `preload` pulse while the controller is not parked has no effect on the accumulator.
- R10: During a run the accumulator changes only at the clock edge that ends step 9. Through steps 0 to 9, `acc_out` shows the starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Restarts the schedule at step 0 |
| preload | input | 1 | Writes `preload_data` into the accumulator while parked |
| preload_data | input | WIDTH | Starting accumulator value |
| done | output | 1 | High while parked in the terminal step |
| acc_out | output | WIDTH | Current accumulator contents |

## Verification
The assertions check the following on every cycle. The step counter restarts, advances and holds as required. The decoded step lines are one-hot. At most one bus driver is enabled, and no register loads from an idle bus. The accumulator is written only in step 9 or by a preload while parked. The bench scenarios cover what the assertions cannot: that the result really equals five times the starting value with wrap-around, that `done` rises at the right cycle, and that a mid-run restart or a preload during a run still gives the correct product.

// File: rtl/mul5_pkg.sv
package mul5_pkg;
  localparam int STEP_W    = 4;
  localparam int LAST_STEP = 10;
  localparam int NUM_LINES = LAST_STEP + 1;

  typedef struct packed {
    logic load_a;
    logic load_sum;
    logic load_acc;
    logic drv_acc;
    logic drv_sum;
  } ctl_t;
endpackage

// File: rtl/mul5_stepper.sv
module mul5_stepper
  import mul5_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output ctl_t ctl,
  output logic parked
);
  logic [STEP_W-1:0]    step_q, step_d;
  logic [NUM_LINES-1:0] line;

  // next-state process
  always_comb begin
    step_d = step_q;
    if (start)
      step_d = '0;
    else if (step_q != STEP_W'(LAST_STEP))
      step_d = step_q + STEP_W'(1);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= STEP_W'(LAST_STEP);
    else        step_q <= step_d;
  end

  // one-hot step decoder
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
    assign line[i] = (step_q == STEP_W'(i));
  end

  // Moore output table built from the decoded lines
  always_comb begin
    ctl.load_a   = line[0] | line[3] | line[5];
    ctl.load_sum = line[1] | line[4] | line[7];
    ctl.load_acc = line[9];
    ctl.drv_acc  = line[0] | line[1] | line[7];
    ctl.drv_sum  = line[3] | line[4] | line[5] | line[9];
  end

  assign parked = line[LAST_STEP];

  p_start_to_step0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (step_q == '0) && !parked);
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && step_q != STEP_W'(LAST_STEP)) |=> step_q == STEP_W'($past(step_q) + STEP_W'(1)));
  p_hold_terminal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && parked) |=> parked);
  p_decode_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(line));
endmodule

// File: rtl/mul5_datapath.sv
module mul5_datapath
  import mul5_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic             parked,
  input  logic             preload,
  input  logic [WIDTH-1:0] preload_data,
  output logic [WIDTH-1:0] acc_q
);
  logic [WIDTH-1:0] a_q, sum_q, bus, adder;
  logic             acc_en, acc_pre;
  logic [WIDTH-1:0] acc_d;

  // shared bus: enable-selected multiplexer, idle value is don't-care
  always_comb begin
    bus = '0;
    if (ctl.drv_acc)      bus = acc_q;
    else if (ctl.drv_sum) bus = sum_q;
  end

  assign adder   = a_q + bus;
  assign acc_pre = preload & parked;
  assign acc_en  = ctl.load_acc | acc_pre;
  assign acc_d   = ctl.load_acc ? bus : preload_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
      sum_q <= '0;
    end else begin
      if (acc_en)       acc_q <= acc_d;
      if (ctl.load_a)   a_q   <= bus;
      if (ctl.load_sum) sum_q <= adder;
    end
  end

  p_single_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl.drv_acc, ctl.drv_sum}) <= 1);
  p_no_idle_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load_a || ctl.load_sum || ctl.load_acc) |-> (ctl.drv_acc || ctl.drv_sum));
  p_preload_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !parked && !ctl.load_acc) |=> acc_q == $past(acc_q));
  p_acc_write_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load_acc && !(preload && parked)) |=> $stable(acc_q));
endmodule

// File: rtl/mul5_sequencer.sv
module mul5_sequencer
  import mul5_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             preload,
  input  logic [WIDTH-1:0] preload_data,
  output logic             done,
  output logic [WIDTH-1:0] acc_out
);
  ctl_t ctl;
  logic parked;

  mul5_stepper u_stepper (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ctl    (ctl),
    .parked (parked)
  );

  mul5_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .parked       (parked),
    .preload      (preload),
    .preload_data (preload_data),
    .acc_q        (acc_out)
  );

  assign done = parked;

  p_done_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !preload) |=> done && $stable(acc_out));
endmodule

// File: tb/mul5_sequencer_tb.sv
`timescale 1ns/1ps
module mul5_sequencer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         preload = 1'b0;
  logic [W-1:0] preload_data = '0;
  logic         done;
  logic [W-1:0] acc_out;

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int popped = 0;
  logic [W-1:0] expq[$];
  logic done_q = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mul5_sequencer #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .preload(preload),
    .preload_data(preload_data), .done(done), .acc_out(acc_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop an expected result at every rising edge of done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_q) begin
        popped++;
        if (expq.size() == 0) check(1'b0, "R5 unexpected done", acc_out, -1);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(acc_out == e, "R5 product", acc_out, e);
        end
      end
      done_q <= done;
    end
  end

  task automatic do_preload(input logic [W-1:0] x);
    @(negedge clk); preload = 1'b1; preload_data = x;
    @(negedge clk); preload = 1'b0;
    check(acc_out == x, "R2 preload", acc_out, x);
  endtask

  // pulse start, push expected, then follow the schedule step by step
  task automatic run(input logic [W-1:0] x, input int restart_at, input int preload_at);
    @(negedge clk); start = 1'b1;
    expq.push_back(W'(x * 5)); pushed++;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R3 done low after start", done, 0);
    for (int i = 1; i <= 10; i++) begin
      if (i == restart_at) start = 1'b1;
      if (i == preload_at) begin preload = 1'b1; preload_data = ~x; end
      @(negedge clk);
      start = 1'b0; preload = 1'b0;
      if (i == restart_at) begin
        check(done == 1'b0, "R8 restart holds done low", done, 0);
        i = 0;
        restart_at = -1;
      end else if (i < 10) begin
        check(done == 1'b0, "R4 done low mid-run", done, 0);
        check(acc_out == x, "R10 acc steady mid-run", acc_out, x);
      end else begin
        check(done == 1'b1, "R4 done at tenth edge", done, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b1 && acc_out == 0, "R1 reset state", acc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b1 && acc_out == 0, "R1 after release", acc_out, 0);

    do_preload(8'd7);   run(8'd7, -1, -1);
    do_preload(8'd200); run(8'd200, -1, -1);
    do_preload(8'd255); run(8'd255, -1, -1);
    do_preload(8'd0);   run(8'd0, -1, -1);
    do_preload(8'd3);   run(8'd3, -1, -1);
    run(8'd15, -1, -1); // chained run: 15 -> 75

    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 parked done", done, 1);
    check(acc_out == 8'd75, "R7 parked acc", acc_out, 75);

    do_preload(8'd11); run(8'd11, 4, -1);   // R8 mid-run restart
    do_preload(8'd9);  run(8'd9, -1, 5);    // R9 preload ignored during run

    repeat (3) @(negedge clk);
    check(expq.size() == 0 && pushed == popped, "R5 scoreboard drained", popped, pushed);
    finished = 1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) check(1'b0, "R4 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (finished);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule